// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog. A prescaler divides the system clock into ticks (0.6 s each in the default build), and a 10-bit down-counter loses one count per tick, starting from a programmable initial value. Software keeps the system alive by writing the reload register. Writing that register puts the counter back to its initial value. Software can also halt the timer and clear its status flags.

Escalation happens in two stages. The first expiry only sets a timeout flag, drives an optional interrupt and restarts the countdown. If the timer expires again while that flag is still set, the block sets the second-timeout and boot flags and sends a one-cycle system reset request. A no-reboot control bit, or a no-reboot strap pin, suppresses that request. Counting and status updates carry on regardless.

All registers are 16 bits wide and are written as whole words. Reads are registered: the data for the address presented at one clock edge appears on `bus_rdata` after that edge.

Top module: `wdt_two_stage`

## Requirements
- R1: While running, the counter decrements once every TICK_CYCLES clocks. The prescaler restarts from zero whenever the timer is halted or reloaded.
- R2: The initial-value register (offset 0x8) keeps only bits 9:0 of a write, and bits 15:10 read as zero. A write whose bits 9:0 are 0 to 3 is ignored and the old value stays.
- R3: Any write to offset 0x0 loads the counter with the initial value, and this takes priority over a tick in the same cycle. A read of offset 0x0 returns the counter in bits 9:0.
- R4: The control register (offset 0x6, all 16 bits read back) freezes the counter and the prescaler while bit 11 (halt) is 1.
- R5: A tick at count 0 with no reload is an expiry, and the counter reloads. If status-1 (offset 0x2) bit 3 is clear, the expiry is the first one and sets that bit.
- R6: `irq_o` is high one cycle after status-1 bit 3 becomes set, but only while bit 13 of the interrupt-enable register (offset 0xA) is 1.
- R7: An expiry while status-1 bit 3 is set is a second expiry. It sets status-2 (offset 0x4) bits 1 and 2 and produces a `rst_req_o` pulse exactly one cycle wide.
- R8: Status bits are write-one-to-clear. Writing 0 to a status bit leaves it unchanged, and a set event in the same cycle wins over a clear.
- R9: When control bit 0 or `no_reboot_strap` is 1 at the second expiry, no reset pulse is sent, but the status bits still set and counting continues.
- R10: After reset, control reads 0x0800, the initial value and the counter equal INIT_DEFAULT, all status bits are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| no_reboot_strap | input | 1 | Strap that blocks reset requests |
| irq_o | output | 1 | Timeout interrupt (level) |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A write takes effect at the clock edge that samples it. Read data, `irq_o` and `rst_req_o` are registered, so each one is due one edge after the state or address it reflects. The bench updates a cycle model of the register file at every rising edge, using the same inputs and only the values from before that edge. It compares all three outputs at the following falling edge, so every comparison lands exactly in the cycle the result is due. The directed checks that wait for an expiry read the status registers only after a wait much longer than the countdown, so they do not depend on the exact tick phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 10;
  localparam int MIN_INIT = 4;

  // Register offsets
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STS1   = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_STS2   = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_IRQEN  = 4'hA;

  // Bit positions
  localparam int BIT_HALT     = 11;
  localparam int BIT_NOREBOOT = 0;
  localparam int BIT_FIRST    = 3;
  localparam int BIT_SECOND   = 1;
  localparam int BIT_BOOT     = 2;
  localparam int BIT_IRQEN    = 13;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_CYCLES < 2) ? 1 : $clog2(TICK_CYCLES);
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] phase;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  AST_HALT_PHASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == '0)) else $error("prescaler not held"); // R1
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [CNT_W-1:0] INIT_DEFAULT = 10'd50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [CNT_W-1:0]  init_val,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] irqen_q,
  output logic              reload_stb,
  output logic              clr_first,
  output logic              clr_second,
  output logic              clr_boot
);
  logic wr_init_ok;

  assign reload_stb = bus_we && (bus_addr == OFS_RELOAD);
  assign clr_first  = bus_we && (bus_addr == OFS_STS1) && bus_wdata[BIT_FIRST];
  assign clr_second = bus_we && (bus_addr == OFS_STS2) && bus_wdata[BIT_SECOND];
  assign clr_boot   = bus_we && (bus_addr == OFS_STS2) && bus_wdata[BIT_BOOT];
  assign wr_init_ok = bus_we && (bus_addr == OFS_INIT) &&
                      (bus_wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      init_val <= INIT_DEFAULT;
      ctrl_q   <= DATA_W'(1) << BIT_HALT;
      irqen_q  <= '0;
    end else begin
      if (wr_init_ok) init_val <= bus_wdata[CNT_W-1:0];
      if (bus_we && (bus_addr == OFS_CTRL))  ctrl_q  <= bus_wdata;
      if (bus_we && (bus_addr == OFS_IRQEN)) irqen_q <= bus_wdata;
    end
  end

  AST_INIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    init_val >= CNT_W'(MIN_INIT)) else $error("illegal initial value"); // R2
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter logic [CNT_W-1:0] INIT_DEFAULT = 10'd50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  input  logic             clr_first,
  input  logic             clr_second,
  input  logic             clr_boot,
  input  logic             no_reboot,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             first_sts,
  output logic             second_sts,
  output logic             boot_sts,
  output logic             rst_req,
  output logic             irq
);
  logic expire, exp_first, exp_second, first_nxt;

  assign expire     = tick && (count == '0) && !reload;
  assign exp_first  = expire && !first_sts;
  assign exp_second = expire && first_sts;
  assign first_nxt  = exp_first || (first_sts && !clr_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= INIT_DEFAULT;
      first_sts  <= 1'b0;
      second_sts <= 1'b0;
      boot_sts   <= 1'b0;
      rst_req    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (reload || expire) count <= init_val;
      else if (tick)        count <= count - 1'b1;
      first_sts  <= first_nxt;
      second_sts <= exp_second || (second_sts && !clr_second);
      boot_sts   <= exp_second || (boot_sts && !clr_boot);
      rst_req    <= exp_second && !no_reboot;
      irq        <= first_nxt && irq_en;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req) else $error("reset pulse too long"); // R7
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(second_sts) |-> $past(first_sts)) else $error("second without first"); // R7
  AST_NOREBOOT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(no_reboot)) else $error("reset despite no-reboot"); // R9
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && count != '0) |=> (count == $past(count) - 1'b1))
    else $error("bad decrement"); // R1
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int               TICK_CYCLES  = 150_000_000,
  parameter logic [CNT_W-1:0] INIT_DEFAULT = 10'd50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              no_reboot_strap,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0]  init_val, count;
  logic [DATA_W-1:0] ctrl_q, irqen_q;
  logic reload_stb, clr_first, clr_second, clr_boot, tick;
  logic first_sts, second_sts, boot_sts, halted;

  assign halted = ctrl_q[BIT_HALT];

  wdt_regs #(.INIT_DEFAULT(INIT_DEFAULT)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .init_val(init_val), .ctrl_q(ctrl_q),
    .irqen_q(irqen_q), .reload_stb(reload_stb), .clr_first(clr_first),
    .clr_second(clr_second), .clr_boot(clr_boot)
  );

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk(clk), .rst(rst), .run(!halted), .clr(reload_stb), .tick(tick)
  );

  wdt_counter #(.INIT_DEFAULT(INIT_DEFAULT)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .reload(reload_stb),
    .init_val(init_val), .clr_first(clr_first), .clr_second(clr_second),
    .clr_boot(clr_boot),
    .no_reboot(ctrl_q[BIT_NOREBOOT] || no_reboot_strap),
    .irq_en(irqen_q[BIT_IRQEN]), .count(count), .first_sts(first_sts),
    .second_sts(second_sts), .boot_sts(boot_sts), .rst_req(rst_req_o),
    .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        OFS_RELOAD: bus_rdata <= DATA_W'(count);
        OFS_STS1:   bus_rdata <= DATA_W'(first_sts) << BIT_FIRST;
        OFS_STS2:   bus_rdata <= (DATA_W'(second_sts) << BIT_SECOND) |
                                 (DATA_W'(boot_sts) << BIT_BOOT);
        OFS_CTRL:   bus_rdata <= ctrl_q;
        OFS_INIT:   bus_rdata <= DATA_W'(init_val);
        OFS_IRQEN:  bus_rdata <= irqen_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (halted && !reload_stb) |=> $stable(count)) else $error("count moved while halted"); // R4
  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (rst)
    reload_stb |=> (count == $past(init_val))) else $error("reload missed"); // R3
endmodule

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;
  localparam int TICK = 4;
  localparam logic [9:0] INIT_DEF = 10'd12;

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0, strap = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0, bus_rdata;
  logic irq_o, rst_req_o;
  int checks = 0, fails = 0, pulses = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdt_two_stage #(.TICK_CYCLES(TICK), .INIT_DEFAULT(INIT_DEF)) u_wdt_two_stage (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .no_reboot_strap(strap),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle model from the requirements
  int m_pre;
  logic [9:0] m_cnt, m_init;
  logic [15:0] m_ctrl, m_ien, m_rd;
  logic m_first, m_sec, m_boot, m_rst, m_irq;
  logic [3:0] m_rd_addr;

  function automatic logic [15:0] read_val(input logic [3:0] a);
    case (a)
      4'h0: return {6'b0, m_cnt};
      4'h2: return {12'b0, m_first, 3'b0};
      4'h4: return {13'b0, m_boot, m_sec, 1'b0};
      4'h6: return m_ctrl;
      4'h8: return {6'b0, m_init};
      4'hA: return m_ien;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'h0: return "R1 R3 count";
      4'h2: return "R5 status1";
      4'h4: return "R7 status2";
      4'h6: return "R4 control";
      4'h8: return "R2 init";
      4'hA: return "R6 irqen";
      default: return "R3 unmapped";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = INIT_DEF; m_init = INIT_DEF; m_ctrl = 16'h0800;
      m_ien = 16'h0; m_first = 0; m_sec = 0; m_boot = 0; m_rst = 0;
      m_irq = 0; m_rd = 16'h0; m_rd_addr = 4'h0;
    end else begin
      logic reload, tick, expire, first_e, second_e, fnext;
      m_rd = read_val(bus_addr);
      m_rd_addr = bus_addr;
      reload = bus_we && bus_addr == 4'h0;
      tick = !m_ctrl[11] && m_pre == TICK - 1;
      expire = tick && m_cnt == 0 && !reload;
      first_e = expire && !m_first;
      second_e = expire && m_first;
      if (m_ctrl[11] || reload || tick) m_pre = 0; else m_pre++;
      if (reload || expire) m_cnt = m_init; else if (tick) m_cnt = m_cnt - 1;
      fnext = first_e || (m_first && !(bus_we && bus_addr == 4'h2 && bus_wdata[3]));
      m_sec = second_e || (m_sec && !(bus_we && bus_addr == 4'h4 && bus_wdata[1]));
      m_boot = second_e || (m_boot && !(bus_we && bus_addr == 4'h4 && bus_wdata[2]));
      m_rst = second_e && !(m_ctrl[0] || strap);
      m_irq = fnext && m_ien[13];
      m_first = fnext;
      if (bus_we && bus_addr == 4'h6) m_ctrl = bus_wdata;
      if (bus_we && bus_addr == 4'hA) m_ien = bus_wdata;
      if (bus_we && bus_addr == 4'h8 && bus_wdata[9:0] >= 4) m_init = bus_wdata[9:0];
    end
  end

  // Lockstep comparison, half a cycle after each edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && !finished) begin
      chk("R7 R9 rst_req_o", {15'b0, rst_req_o}, {15'b0, m_rst});
      chk("R6 irq_o", {15'b0, irq_o}, {15'b0, m_irq});
      chk(tag_of(m_rd_addr), bus_rdata, m_rd);
      if (rst_req_o) pulses++;
    end
    if (cyc == 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_we = 1'b0; bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  initial begin
    logic [15:0] v, v2;
    int p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 irq after reset", {15'b0, irq_o}, 16'h0);
    chk("R10 rst_req after reset", {15'b0, rst_req_o}, 16'h0);
    rd(4'h6, v); chk("R10 control reset", v, 16'h0800);
    rd(4'h8, v); chk("R10 init reset", v, {6'b0, INIT_DEF});
    rd(4'h0, v); chk("R10 count reset", v, {6'b0, INIT_DEF});
    rd(4'h2, v); chk("R10 status1 reset", v, 16'h0);
    rd(4'h4, v); chk("R10 status2 reset", v, 16'h0);
    // R2 illegal and masked init writes
    wr(4'h8, 16'h0003); rd(4'h8, v); chk("R2 init 3 ignored", v, {6'b0, INIT_DEF});
    wr(4'h8, 16'h0000); rd(4'h8, v); chk("R2 init 0 ignored", v, {6'b0, INIT_DEF});
    wr(4'h8, 16'hFC07); rd(4'h8, v); chk("R2 upper bits dropped", v, 16'h0007);
    // R1 decrement rate
    wr(4'hA, 16'h2000); wr(4'h6, 16'h0000); wr(4'h0, 16'h0);
    rd(4'h0, v); repeat (7) @(negedge clk); rd(4'h0, v2);
    chk("R1 two ticks in 8 cycles", v - v2, 16'd2);
    // R5 / R6 first expiry
    wr(4'h0, 16'h0); repeat (40) @(negedge clk);
    rd(4'h2, v); chk("R5 first expiry flag", v, 16'h0008);
    chk("R6 irq raised", {15'b0, irq_o}, 16'h1);
    // R7 second expiry
    p0 = pulses; repeat (40) @(negedge clk);
    rd(4'h4, v); chk("R7 second and boot flags", v, 16'h0006);
    chk("R7 exactly one reset pulse", 16'(pulses - p0), 16'd1);
    // R8 write-one-to-clear
    wr(4'h4, 16'h0002); rd(4'h4, v); chk("R8 clear second only", v, 16'h0004);
    wr(4'h4, 16'hFFF9); rd(4'h4, v); chk("R8 zero writes keep", v, 16'h0004);
    wr(4'h6, 16'h0800); wr(4'h2, 16'h0008); rd(4'h2, v); chk("R8 clear first", v, 16'h0);
    chk("R6 irq drops with flag", {15'b0, irq_o}, 16'h0);
    // R4 halt freezes
    rd(4'h0, v); repeat (20) @(negedge clk); rd(4'h0, v2); chk("R4 frozen count", v2, v);
    // R9 no-reboot bit
    wr(4'h4, 16'h0006); p0 = pulses; wr(4'h6, 16'h0001); wr(4'h0, 16'h0);
    repeat (90) @(negedge clk);
    rd(4'h4, v); chk("R9 status still sets", v, 16'h0006);
    chk("R9 no reset pulse", 16'(pulses - p0), 16'd0);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      bus_addr = 4'(($urandom % 6) * 2);
      bus_we = ($urandom % 8) == 0;
      bus_wdata = 16'($urandom);
      if (bus_addr == 4'h6) bus_wdata[11] = ($urandom % 8) == 0;
      if (bus_addr == 4'h6) bus_wdata[0] = ($urandom % 4) == 0;
      if (bus_addr == 4'h8) bus_wdata[9:0] = 10'($urandom % 12);
      if (bus_addr == 4'h0 && ($urandom % 4) != 0) bus_we = 1'b0;
      if (($urandom % 200) == 0) strap = ~strap;
    end
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule